// File: doc/BRIEF.md
# Banked Host Register Window with Packet Buffer Pointer

This block sits between a byte-addressed host bus of sixteen locations and the packet buffer of a network controller. A bank-select location, present at the same address in every bank, chooses which of four register banks the other locations reach. One bank holds a packet-number register, a 16-bit pointer and a four-location data window. Every window access resolves to a page and a byte address in the buffer RAM, which lives outside the block behind a single synchronous port.

Host accesses may be one, two or four bytes wide. A sequencer breaks each one into byte steps at consecutive offsets, lowest first, and processes them in order. An earlier byte can therefore change the bank seen by a later byte. The pointer has two mode bits. One chooses whether the page comes from the packet-number register or from the page at the head of the receive queue, which arrives on an input. The other chooses whether each window byte moves the pointer forward or whether the window offset supplies a byte-lane displacement. The host holds its request until a one-cycle ready pulse, which is raised only after any RAM read data has been captured.

Top module: `bank_window`

## Requirements
- R1: A byte written at offset 14 sets the 2-bit bank select in every bank, and its upper six bits are dropped. A read at offset 14 returns the bank, zero-extended.
- R2: Offset 15 reads 0x33 in every bank. Writes to it change nothing.
- R3: In bank 2, offset 2 is an 8-bit packet-number register that reads back what was written. A window access targets page `rx_head` when pointer bit 15 is 1, and page packet-number[1:0] when it is 0.
- R4: With pointer bit 14 set, a window byte uses byte address pointer[10:0]. The access then adds one to pointer[10:0] modulo 2048 and leaves bits 15:11 unchanged. The RAM address is page*2048 + byte address.
- R5: With pointer bit 14 clear, a window byte at offset 8+k (k = 0..3) uses byte address (pointer[10:0] + k) modulo 2048 and leaves the pointer unchanged.
- R6: In bank 2, offset 6 reads pointer[7:0] and offset 7 reads pointer[15:8] AND 0xF7. Writes to those offsets load the same bytes.
- R7: A 4-byte write at offset 12 drops its two low bytes. Byte 2 of the write data goes to offset 14 and byte 3 goes to offset 15.
- R8: hst_size 0, 1 and 2 (or 3) mean 1, 2 and 4 bytes. Byte i of an access goes to offset (addr+i) mod 16, in ascending order, on data lane i (bits 8i+7:8i). Unused read lanes return 0.
- R9: In bank 0, offset 8 reads the page count (4) and offset 9 reads the number of set bits in `alloc_map`.
- R10: Offsets not named in R1 to R9 read 0, and writes to them change no state.
- R11: Each host access ends with `hst_ready` high for exactly one cycle. A RAM read is never followed by another RAM access in the next cycle, and `ram_we` is only ever high together with `ram_en`.
- R12: After reset the bank, the pointer and the packet number are 0, and `hst_ready` and `ram_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hst_req | input | 1 | Access request, held until hst_ready |
| hst_we | input | 1 | 1 = write, 0 = read |
| hst_addr | input | 4 | Offset of the first byte |
| hst_size | input | 2 | 0: 1 byte, 1: 2 bytes, 2/3: 4 bytes |
| hst_wdata | input | 32 | Write data, byte i on lane i |
| hst_rdata | output | 32 | Read data, valid while hst_ready |
| hst_ready | output | 1 | One-cycle completion pulse |
| alloc_map | input | NUM_PAGES | Pages currently allocated |
| rx_head | input | PAGE_W | Page at the head of the receive queue |
| ram_en | output | 1 | Buffer RAM access strobe |
| ram_we | output | 1 | Buffer RAM write strobe |
| ram_addr | output | RAM_AW | Page and byte address |
| ram_wdata | output | 8 | Buffer RAM write byte |
| ram_rdata | input | 8 | Buffer RAM read byte, one cycle after ram_en |

## Verification
The bench sets the pointer at 0x7FE with auto-increment on and writes four bytes through the window. A design that carried the increment into bit 11, or that stopped at the page edge, would put bytes into the wrong page or return the wrong pointer. Lane-offset addressing is tested across the 2047-to-0 boundary. A design that added the lane before masking would read from the neighbouring page. The 4-byte write at offset 12 uses different values in bytes 0 and 2, so taking the wrong byte leaves a different bank. A 4-byte read at offset 14 shows whether offsets wrap past 15 back to 0. Writes aimed at undefined locations, and at bank-2 addresses while another bank is selected, must leave the pointer and the packet number untouched.

// File: rtl/bwin_pkg.sv
package bwin_pkg;
   typedef enum logic [1:0] {
      SZ_B8   = 2'd0,
      SZ_B16  = 2'd1,
      SZ_B32  = 2'd2,
      SZ_B32A = 2'd3
   } hsize_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_STEP  = 2'd1,
      ST_RWAIT = 2'd2,
      ST_DONE  = 2'd3
   } seq_st_e;

   localparam logic [1:0] BANK_CTL = 2'd0;
   localparam logic [1:0] BANK_MMU = 2'd2;

   localparam logic [3:0] OFF_PNUM  = 4'd2;
   localparam logic [3:0] OFF_PTRL  = 4'd6;
   localparam logic [3:0] OFF_PTRH  = 4'd7;
   localparam logic [3:0] OFF_PGCNT = 4'd8;
   localparam logic [3:0] OFF_PGUSE = 4'd9;
   localparam logic [3:0] OFF_WIDE  = 4'd12;
   localparam logic [3:0] OFF_BANK  = 4'd14;
   localparam logic [3:0] OFF_ID    = 4'd15;

   localparam int PTR_SRC_BIT = 15;
   localparam int PTR_INC_BIT = 14;
   localparam logic [7:0] PTRH_RD_MASK = 8'hF7;
endpackage

// File: rtl/bwin_seq.sv
module bwin_seq
   import bwin_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        hst_req,
   input  logic        hst_we,
   input  logic [3:0]  hst_addr,
   input  logic [1:0]  hst_size,
   input  logic [31:0] hst_wdata,
   output logic [31:0] hst_rdata,
   output logic        hst_ready,
   output logic        b_valid,
   output logic        b_we,
   output logic [3:0]  b_off,
   output logic [7:0]  b_wdata,
   input  logic        win_hit,
   input  logic [7:0]  reg_rdata,
   input  logic [7:0]  ram_rdata,
   output logic        ram_en,
   output logic        ram_we
);
   seq_st_e     st_q;
   logic [3:0]  base_q;
   logic [1:0]  idx_q;
   logic [1:0]  last_q;
   logic        we_q;
   logic [31:0] wd_q;
   logic [31:0] rd_q;
   logic        wait_rd;
   logic [1:0]  last_d;
   logic        wide_d;

   assign b_valid   = (st_q == ST_STEP);
   assign b_we      = we_q;
   assign b_off     = base_q + {2'b00, idx_q};
   assign b_wdata   = wd_q[{idx_q, 3'b000} +: 8];
   assign ram_en    = b_valid && win_hit;
   assign ram_we    = ram_en && we_q;
   assign wait_rd   = ram_en && !we_q;
   assign hst_ready = (st_q == ST_DONE);
   assign hst_rdata = rd_q;

   always_comb begin
      wide_d = 1'b0;
      case (hsize_e'(hst_size))
         SZ_B8:   last_d = 2'd0;
         SZ_B16:  last_d = 2'd1;
         default: begin
            last_d = 2'd3;
            wide_d = 1'b1;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         base_q <= '0;
         idx_q  <= '0;
         last_q <= '0;
         we_q   <= 1'b0;
         wd_q   <= '0;
         rd_q   <= '0;
      end else begin
         case (st_q)
            ST_IDLE: begin
               if (hst_req) begin
                  base_q <= hst_addr;
                  we_q   <= hst_we;
                  wd_q   <= hst_wdata;
                  rd_q   <= '0;
                  last_q <= last_d;
                  // wide write at offset 12 only reaches the bank byte and above
                  idx_q  <= (hst_we && wide_d && hst_addr == OFF_WIDE) ? 2'd2 : 2'd0;
                  st_q   <= ST_STEP;
               end
            end
            ST_STEP: begin
               if (wait_rd) begin
                  st_q <= ST_RWAIT;
               end else begin
                  if (!we_q) rd_q[{idx_q, 3'b000} +: 8] <= reg_rdata;
                  if (idx_q == last_q) st_q <= ST_DONE;
                  else idx_q <= idx_q + 2'd1;
               end
            end
            ST_RWAIT: begin
               rd_q[{idx_q, 3'b000} +: 8] <= ram_rdata;
               if (idx_q == last_q) begin
                  st_q <= ST_DONE;
               end else begin
                  idx_q <= idx_q + 2'd1;
                  st_q  <= ST_STEP;
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   // R11: completion is a single-cycle pulse
   p_ready_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
      hst_ready |=> !hst_ready);
   // R11: a write strobe never appears without the access strobe
   p_we_with_en_r11: assert property (@(posedge clk) disable iff (!rst_n)
      ram_we |-> ram_en);
   // R11: the cycle after a RAM read is left free for the returning data
   p_read_gap_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (ram_en && !ram_we) |=> !ram_en);
endmodule

// File: rtl/bwin_regs.sv
module bwin_regs
   import bwin_pkg::*;
#(
   parameter int         NUM_PAGES = 4,
   parameter int         PAGE_W    = 2,
   parameter logic [7:0] ID_VALUE  = 8'h33
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 b_valid,
   input  logic                 b_we,
   input  logic [3:0]           b_off,
   input  logic [7:0]           b_wdata,
   input  logic [NUM_PAGES-1:0] alloc_map,
   input  logic [15:0]          ptr,
   output logic [7:0]           reg_rdata,
   output logic                 win_hit,
   output logic                 win_acc,
   output logic                 ptr_wr_lo,
   output logic                 ptr_wr_hi,
   output logic [PAGE_W-1:0]    pnum_page
);
   localparam int CNT_W = $clog2(NUM_PAGES + 1);

   generate
      if (NUM_PAGES < 2 || NUM_PAGES > 255 || (NUM_PAGES & (NUM_PAGES - 1)) != 0) begin : g_bad_pages
         $error("NUM_PAGES must be a power of two between 2 and 128");
      end
   endgenerate

   logic [1:0]       bank_q;
   logic [7:0]       pnum_q;
   logic             bank_wr;
   logic             mmu_wr;
   logic [CNT_W-1:0] psum [NUM_PAGES+1];

   assign bank_wr   = b_valid && b_we && (b_off == OFF_BANK);
   assign mmu_wr    = b_valid && b_we && (bank_q == BANK_MMU);
   assign ptr_wr_lo = mmu_wr && (b_off == OFF_PTRL);
   assign ptr_wr_hi = mmu_wr && (b_off == OFF_PTRH);
   assign win_hit   = (bank_q == BANK_MMU) && (b_off[3:2] == 2'b10);
   assign win_acc   = b_valid && win_hit;
   assign pnum_page = pnum_q[PAGE_W-1:0];

   assign psum[0] = '0;
   generate
      for (genvar g = 0; g < NUM_PAGES; g++) begin : g_pop
         assign psum[g+1] = psum[g] + CNT_W'(alloc_map[g]);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bank_q <= '0;
         pnum_q <= '0;
      end else begin
         if (bank_wr) bank_q <= b_wdata[1:0];
         if (mmu_wr && b_off == OFF_PNUM) pnum_q <= b_wdata;
      end
   end

   always_comb begin
      reg_rdata = '0;
      if (b_off == OFF_BANK) begin
         reg_rdata = {6'b0, bank_q};
      end else if (b_off == OFF_ID) begin
         reg_rdata = ID_VALUE;
      end else begin
         case (bank_q)
            BANK_CTL: begin
               if (b_off == OFF_PGCNT)      reg_rdata = 8'(NUM_PAGES);
               else if (b_off == OFF_PGUSE) reg_rdata = 8'(psum[NUM_PAGES]);
            end
            BANK_MMU: begin
               if (b_off == OFF_PNUM)      reg_rdata = pnum_q;
               else if (b_off == OFF_PTRL) reg_rdata = ptr[7:0];
               else if (b_off == OFF_PTRH) reg_rdata = ptr[15:8] & PTRH_RD_MASK;
            end
            default: reg_rdata = '0;
         endcase
      end
   end

   // R1: the bank only moves on a write to the select location
   p_bank_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !bank_wr |=> $stable(bank_q));
   // R3: the packet number only moves on its own write
   p_pnum_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(mmu_wr && b_off == OFF_PNUM) |=> $stable(pnum_q));
endmodule

// File: rtl/bwin_ptr.sv
module bwin_ptr
   import bwin_pkg::*;
#(
   parameter int PAGE_W = 2,
   parameter int OFS_W  = 11
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_lo,
   input  logic                    wr_hi,
   input  logic [7:0]              wdata,
   input  logic                    acc,
   input  logic [1:0]              lane,
   input  logic [PAGE_W-1:0]       rx_head,
   input  logic [PAGE_W-1:0]       pnum_page,
   output logic [15:0]             ptr_q,
   output logic [PAGE_W+OFS_W-1:0] ram_addr
);
   generate
      if (OFS_W < 2 || OFS_W > 11) begin : g_bad_ofs
         $error("page offset must be 2 to 11 bits wide");
      end
   endgenerate

   logic [PAGE_W-1:0] page;
   logic [OFS_W-1:0]  ofs;
   logic [OFS_W-1:0]  byte_addr;
   logic              inc_mode;

   assign inc_mode  = ptr_q[PTR_INC_BIT];
   assign ofs       = ptr_q[OFS_W-1:0];
   assign page      = ptr_q[PTR_SRC_BIT] ? rx_head : pnum_page;
   assign byte_addr = inc_mode ? ofs : OFS_W'(ofs + OFS_W'(lane));
   assign ram_addr  = {page, byte_addr};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q <= '0;
      end else if (wr_lo) begin
         ptr_q[7:0] <= wdata;
      end else if (wr_hi) begin
         ptr_q[15:8] <= wdata;
      end else if (acc && inc_mode) begin
         ptr_q[OFS_W-1:0] <= OFS_W'(ofs + 1'b1);
      end
   end

   // R4: post-increment wraps inside the offset field and keeps the upper bits
   p_autoinc_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && inc_mode) |=> (ptr_q[OFS_W-1:0] == OFS_W'($past(ptr_q[OFS_W-1:0]) + 1'b1))
                            && (ptr_q[15:OFS_W] == $past(ptr_q[15:OFS_W])));
   // R5: lane addressing leaves the pointer alone
   p_lane_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && !inc_mode) |=> $stable(ptr_q));
endmodule

// File: rtl/bank_window.sv
module bank_window
   import bwin_pkg::*;
#(
   parameter int         NUM_PAGES  = 4,
   parameter int         PAGE_BYTES = 2048,
   parameter logic [7:0] ID_VALUE   = 8'h33,
   localparam int        PAGE_W     = $clog2(NUM_PAGES),
   localparam int        OFS_W      = $clog2(PAGE_BYTES),
   localparam int        RAM_AW     = PAGE_W + OFS_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 hst_req,
   input  logic                 hst_we,
   input  logic [3:0]           hst_addr,
   input  logic [1:0]           hst_size,
   input  logic [31:0]          hst_wdata,
   output logic [31:0]          hst_rdata,
   output logic                 hst_ready,
   input  logic [NUM_PAGES-1:0] alloc_map,
   input  logic [PAGE_W-1:0]    rx_head,
   output logic                 ram_en,
   output logic                 ram_we,
   output logic [RAM_AW-1:0]    ram_addr,
   output logic [7:0]           ram_wdata,
   input  logic [7:0]           ram_rdata
);
   generate
      if ((PAGE_BYTES & (PAGE_BYTES - 1)) != 0) begin : g_bad_page_bytes
         $error("PAGE_BYTES must be a power of two");
      end
   endgenerate

   logic              b_valid;
   logic              b_we;
   logic [3:0]        b_off;
   logic [7:0]        b_wdata;
   logic              win_hit;
   logic              win_acc;
   logic [7:0]        reg_rdata;
   logic              ptr_wr_lo;
   logic              ptr_wr_hi;
   logic [PAGE_W-1:0] pnum_page;
   logic [15:0]       ptr;

   assign ram_wdata = b_wdata;

   bwin_seq u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .hst_req   (hst_req),
      .hst_we    (hst_we),
      .hst_addr  (hst_addr),
      .hst_size  (hst_size),
      .hst_wdata (hst_wdata),
      .hst_rdata (hst_rdata),
      .hst_ready (hst_ready),
      .b_valid   (b_valid),
      .b_we      (b_we),
      .b_off     (b_off),
      .b_wdata   (b_wdata),
      .win_hit   (win_hit),
      .reg_rdata (reg_rdata),
      .ram_rdata (ram_rdata),
      .ram_en    (ram_en),
      .ram_we    (ram_we)
   );

   bwin_regs #(
      .NUM_PAGES (NUM_PAGES),
      .PAGE_W    (PAGE_W),
      .ID_VALUE  (ID_VALUE)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .b_valid   (b_valid),
      .b_we      (b_we),
      .b_off     (b_off),
      .b_wdata   (b_wdata),
      .alloc_map (alloc_map),
      .ptr       (ptr),
      .reg_rdata (reg_rdata),
      .win_hit   (win_hit),
      .win_acc   (win_acc),
      .ptr_wr_lo (ptr_wr_lo),
      .ptr_wr_hi (ptr_wr_hi),
      .pnum_page (pnum_page)
   );

   bwin_ptr #(
      .PAGE_W (PAGE_W),
      .OFS_W  (OFS_W)
   ) u_ptr (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_lo     (ptr_wr_lo),
      .wr_hi     (ptr_wr_hi),
      .wdata     (b_wdata),
      .acc       (win_acc),
      .lane      (b_off[1:0]),
      .rx_head   (rx_head),
      .pnum_page (pnum_page),
      .ptr_q     (ptr),
      .ram_addr  (ram_addr)
   );
endmodule

// File: tb/bank_window_bench.sv
module bank_window_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        hst_req = 1'b0;
   logic        hst_we = 1'b0;
   logic [3:0]  hst_addr = '0;
   logic [1:0]  hst_size = '0;
   logic [31:0] hst_wdata = '0;
   logic [31:0] hst_rdata;
   logic        hst_ready;
   logic [3:0]  alloc_map = '0;
   logic [1:0]  rx_head = '0;
   logic        ram_en;
   logic        ram_we;
   logic [12:0] ram_addr;
   logic [7:0]  ram_wdata;
   logic [7:0]  ram_rdata = '0;

   int n_chk = 0;
   int n_err = 0;

   always #10 clk = ~clk;

   bank_window u_bank_window (
      .clk(clk), .rst_n(rst_n), .hst_req(hst_req), .hst_we(hst_we),
      .hst_addr(hst_addr), .hst_size(hst_size), .hst_wdata(hst_wdata),
      .hst_rdata(hst_rdata), .hst_ready(hst_ready), .alloc_map(alloc_map),
      .rx_head(rx_head), .ram_en(ram_en), .ram_we(ram_we), .ram_addr(ram_addr),
      .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
   );

   // buffer RAM model: untouched bytes hold an address-derived pattern
   logic [7:0] mem [int];

   function automatic logic [7:0] pat(int a);
      return 8'((a ^ (a >> 5) ^ 32'hA5) & 255);
   endfunction

   function automatic logic [7:0] memrd(int a);
      if (mem.exists(a)) return mem[a];
      return pat(a);
   endfunction

   always @(posedge clk) begin
      if (ram_en) begin
         if (ram_we) mem[int'(ram_addr)] = ram_wdata;
         else ram_rdata <= memrd(int'(ram_addr));
      end
   end

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // scoreboard
   bit          sb_chk[$];
   logic [31:0] sb_exp[$];
   string       sb_tag[$];

   always @(negedge clk) begin
      if (rst_n && hst_ready) begin
         if (sb_chk.size() == 0) begin
            check("R11 ready without a request", 32'd1, 32'd0);
         end else begin
            bit          c;
            logic [31:0] e;
            string       t;
            c = sb_chk.pop_front();
            e = sb_exp.pop_front();
            t = sb_tag.pop_front();
            if (c) check(t, hst_rdata, e);
         end
      end
   end

   task automatic acc(bit we, logic [3:0] a, logic [1:0] sz, logic [31:0] wd,
                      logic [31:0] exp, string tag);
      sb_chk.push_back(!we);
      sb_exp.push_back(exp);
      sb_tag.push_back(tag);
      @(negedge clk);
      hst_req   = 1'b1;
      hst_we    = we;
      hst_addr  = a;
      hst_size  = sz;
      hst_wdata = wd;
      do @(negedge clk); while (!hst_ready);
      hst_req = 1'b0;
      @(negedge clk);
      check("R11 ready lasts one cycle", 32'(hst_ready), 32'd0);
   endtask

   task automatic wr(logic [3:0] a, logic [1:0] sz, logic [31:0] wd);
      acc(1'b1, a, sz, wd, 32'd0, "write");
   endtask

   task automatic rd(logic [3:0] a, logic [1:0] sz, logic [31:0] exp, string tag);
      acc(1'b0, a, sz, 32'd0, exp, tag);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R12 ready low in reset", 32'(hst_ready), 32'd0);
      check("R12 ram_en low in reset", 32'(ram_en), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R12 ready low after reset", 32'(hst_ready), 32'd0);
      rd(4'd14, 2'd0, 32'd0, "R12 bank after reset");

      // R1 bank select, upper bits dropped
      wr(4'd14, 2'd0, 32'h06);
      rd(4'd14, 2'd0, 32'd2, "R1 bank readback");
      rd(4'd2, 2'd0, 32'd0, "R12 packet number after reset");
      rd(4'd6, 2'd1, 32'd0, "R12 pointer after reset");

      // R2 identification byte
      rd(4'd15, 2'd0, 32'h33, "R2 id in bank 2");
      wr(4'd15, 2'd0, 32'h55);
      rd(4'd15, 2'd0, 32'h33, "R2 id after write");
      rd(4'd14, 2'd0, 32'd2, "R2 write to id leaves bank");

      // R9 page count and used pages
      alloc_map = 4'b1011;
      wr(4'd14, 2'd0, 32'h00);
      rd(4'd8, 2'd1, 32'h0000_0304, "R9 R8 page count and used");
      rd(4'd15, 2'd0, 32'h33, "R2 id in bank 0");
      rd(4'd3, 2'd0, 32'd0, "R10 undefined bank 0 read");

      // R3 R6 packet number and pointer
      wr(4'd14, 2'd0, 32'h02);
      wr(4'd2, 2'd0, 32'h81);
      rd(4'd2, 2'd0, 32'h81, "R3 packet number readback");
      wr(4'd6, 2'd1, 32'h4FFE);
      rd(4'd7, 2'd0, 32'h47, "R6 pointer high masked");
      rd(4'd6, 2'd0, 32'hFE, "R6 pointer low");

      // R4 auto-increment across the page end
      wr(4'd8, 2'd2, 32'hDDCC_BBAA);
      check("R4 byte at 7FE", 32'(memrd(2048 + 12'h7FE)), 32'hAA);
      check("R4 byte at 7FF", 32'(memrd(2048 + 12'h7FF)), 32'hBB);
      check("R4 wrap to 000", 32'(memrd(2048 + 0)), 32'hCC);
      check("R4 byte at 001", 32'(memrd(2048 + 1)), 32'hDD);
      rd(4'd6, 2'd1, 32'h0000_4002, "R4 pointer after four bytes");

      // R5 lane-offset addressing
      wr(4'd6, 2'd1, 32'h0100);
      rd(4'd8, 2'd2, {pat(2048 + 12'h103), pat(2048 + 12'h102),
                      pat(2048 + 12'h101), pat(2048 + 12'h100)}, "R5 four lanes");
      rd(4'd6, 2'd1, 32'h0000_0100, "R5 pointer unchanged");
      wr(4'd10, 2'd0, 32'h5A);
      check("R5 write on lane 2", 32'(memrd(2048 + 12'h102)), 32'h5A);
      rd(4'd10, 2'd0, 32'h5A, "R5 read on lane 2");
      wr(4'd6, 2'd1, 32'h07FF);
      rd(4'd10, 2'd1, {16'h0, pat(2048 + 2), 8'hDD}, "R5 lane wrap in page");

      // R3 page from packet number and from receive head
      wr(4'd2, 2'd0, 32'h02);
      wr(4'd6, 2'd1, 32'h0005);
      rd(4'd8, 2'd0, 32'(pat(4096 + 5)), "R3 page from packet number");
      rx_head = 2'd3;
      wr(4'd6, 2'd1, 32'hC000);
      rd(4'd8, 2'd0, 32'(pat(3 * 2048)), "R3 page from receive head");
      rd(4'd6, 2'd0, 32'h01, "R4 increment after read");

      // R8 offset wrap
      rd(4'd14, 2'd2, 32'h0000_3302, "R8 wide read wraps offsets");

      // R10 undefined locations
      wr(4'd12, 2'd1, 32'hFFFF);
      wr(4'd3, 2'd0, 32'hAA);
      wr(4'd1, 2'd0, 32'hAA);
      rd(4'd12, 2'd1, 32'd0, "R10 undefined read zero");
      rd(4'd6, 2'd1, 32'h0000_C001, "R10 pointer untouched");
      rd(4'd2, 2'd0, 32'h02, "R10 packet number untouched");
      wr(4'd14, 2'd0, 32'h01);
      wr(4'd2, 2'd0, 32'h77);
      wr(4'd6, 2'd1, 32'h1234);
      rd(4'd6, 2'd1, 32'd0, "R10 bank 1 reads zero");
      wr(4'd14, 2'd0, 32'h02);
      rd(4'd2, 2'd0, 32'h02, "R10 other bank left packet number");
      rd(4'd6, 2'd1, 32'h0000_C001, "R10 other bank left pointer");

      // R7 wide write at offset 12
      wr(4'd12, 2'd2, 32'h0003_0201);
      rd(4'd14, 2'd0, 32'd3, "R7 only byte 2 reaches bank");
      rd(4'd15, 2'd0, 32'h33, "R2 id in bank 3");
      wr(4'd14, 2'd1, 32'h5501);
      rd(4'd14, 2'd0, 32'd1, "R8 half write splits bytes");

      repeat (4) @(negedge clk);
      check("R8 scoreboard drained", 32'(sb_chk.size()), 32'd0);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule